// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter whose comparator is shared between eight analog inputs. A one-cycle start request, taken while the block is idle, latches a channel number and a clock-rate choice and begins a conversion. The block first holds the sample-and-hold open for a fixed sampling window, then presents a trial code to an external DAC once per bit, MSB first, and keeps or drops each bit according to the single comparator bit that comes back.

Every conversion occupies exactly 160 periods of the converter clock. The first 12 periods are the sampling window. The remaining periods are split into eight equal trial slots. Any periods left over are idle padding at the end. The converter clock is either the system clock or half of it, as picked at start. The 8-bit result register changes only when a conversion ends, in the same cycle as a one-cycle done pulse.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy, done, sample_en and result are all 0.
- R2: A start seen high at a clock edge while busy is low starts a conversion, and busy is high from the next cycle.
- R3: sample_en is high for exactly the first 12 converter periods of a conversion, and low at all other times.
- R4: busy stays high for exactly 160 converter periods. It falls in the same cycle that done rises.
- R5: slow_clk_sel is sampled at start. A value of 0 makes one converter period equal to one system cycle, so a conversion takes 160 cycles. A value of 1 makes one period two system cycles, so a conversion takes 320 cycles.
- R6: The result is found one bit per trial slot, MSB first. cmp_in = 1 during a slot means the input is at or above dac_code, and the trial bit is kept. An ideal comparator yields result equal to the input value.
- R7: Input values 00h, 80h and FFh convert to exactly 00h, 80h and FFh.
- R8: A start request while busy is high is ignored. The conversion in progress keeps its channel and its end time.
- R9: chan_sel (3 bits) is latched at the accepted start and drives mux_sel unchanged for the whole conversion, whatever chan_sel does afterwards.
- R10: result changes only in the cycle where done is high, and done is high for a single cycle per conversion.
- R11: In the first converter period after sampling ends, dac_code is 80h, which is the MSB trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, honoured only while idle |
| chan_sel | input | 3 | Analog channel to convert |
| slow_clk_sel | input | 1 | 0: converter clock = system clock; 1: system clock / 2 |
| cmp_in | input | 1 | Comparator bit, 1 when the input is at or above dac_code |
| mux_sel | output | 3 | Latched channel select to the analog multiplexer |
| sample_en | output | 1 | Sample-and-hold enable during the sampling window |
| dac_code | output | 8 | Trial code for the external DAC |
| result | output | 8 | Last completed conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse at conversion end |

## Verification
A frame counter that is off by a single count shows up at once. The fall of sample_en moves, and the done pulse lands one converter period early or late. The bench checks both on exact cycles at both clock rates. A corrupted trial mask or accumulator shows only at the end of the frame, as a wrong result. Converting random input values, plus the extreme codes and mid-scale, exposes any bit that is dropped or kept wrongly. A start taken while busy would restart the counters. That moves done and changes mux_sel, and both are checked in the same run.

// File: rtl/sar_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: consumers compare phases only for equality.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_PAD    = 2'd3
    } sar_phase_t;
endpackage

// File: rtl/sar_tick_gen.sv
// Converter clock enable. It produces one tick per converter period: on every
// system cycle, or on every second one when the slow rate was chosen at start.
// Assumes: start_acc only occurs while run is low.
module sar_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic run,
    input  logic div_sel,
    output logic tick
);
    logic div_q;
    logic ph_q;

    // Latch the rate at start and toggle the divider phase while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
            ph_q  <= 1'b0;
        end else if (start_acc) begin
            div_q <= div_sel;
            ph_q  <= 1'b0;
        end else if (run) begin
            ph_q  <= ~ph_q;
        end
    end

    assign tick = run & (~div_q | ph_q);

    AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_q && tick) |=> !tick); // R5
endmodule

// File: rtl/sar_frame_ctl.sv
// Frame timing. It counts converter periods across the frame, tracks the
// sampling, trial and padding phases, and flags the end of each trial slot
// and the end of the frame.
// Assumes: FRAME_LEN >= SAMPLE_LEN + RES_BITS * slot length.
module sar_frame_ctl
    import sar_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int FRAME_LEN  = 160,
    parameter int SAMPLE_LEN = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_acc,
    input  logic       tick,
    output logic       busy,
    output sar_phase_t phase,
    output logic       trial_end,
    output logic       frame_end
);
    localparam int SLOT_LEN = (FRAME_LEN - SAMPLE_LEN) / RES_BITS;
    localparam int CNT_W    = $clog2(FRAME_LEN);
    localparam int SLOT_W   = $clog2(SLOT_LEN);
    localparam int IDX_W    = $clog2(RES_BITS + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  idx_q;

    // Pick the phase from the frame position and the completed trial count.
    always_comb begin
        if (!busy)                                phase = PH_IDLE;
        else if (cnt_q < CNT_W'(SAMPLE_LEN))      phase = PH_SAMPLE;
        else if (idx_q < IDX_W'(RES_BITS))        phase = PH_TRIAL;
        else                                      phase = PH_PAD;
    end

    assign frame_end = tick & (cnt_q == CNT_W'(FRAME_LEN - 1));
    assign trial_end = tick & (phase == PH_TRIAL) & (slot_q == SLOT_W'(SLOT_LEN - 1));

    // Hold busy from the accepted start to the last period of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_acc) busy <= 1'b1;
        else if (frame_end) busy <= 1'b0;
    end

    // Advance the frame position once per converter period.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end

    // Step through the trial slots and count the trials that have finished.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            slot_q <= '0;
            idx_q  <= '0;
        end else if (trial_end) begin
            slot_q <= '0;
            idx_q  <= idx_q + 1'b1;
        end else if (tick && phase == PH_TRIAL) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end) |=> busy); // R4
    AST_TRIALS_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (phase == PH_PAD)); // R6
endmodule

// File: rtl/sar_bit_reg.sv
// Successive-approximation register. A one-hot mask walks from the MSB down.
// At the end of each slot the masked bit is kept when the comparator says the
// input is at or above the trial code.
// Assumes: trial_end pulses exactly RES_BITS times per conversion.
module sar_bit_reg #(
    parameter int RES_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_acc,
    input  logic                trial_on,
    input  logic                trial_end,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] value
);
    logic [RES_BITS-1:0] mask_q;
    logic [RES_BITS-1:0] acc_q;

    // Reload at start, then settle one bit per trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            acc_q  <= '0;
        end else if (start_acc) begin
            mask_q <= {1'b1, {(RES_BITS-1){1'b0}}};
            acc_q  <= '0;
        end else if (trial_end) begin
            if (cmp_in) acc_q <= acc_q | mask_q;
            mask_q <= mask_q >> 1;
        end
    end

    assign code  = trial_on ? (acc_q | mask_q) : '0;
    assign value = acc_q;

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q)); // R11
endmodule

// File: rtl/sar_adc_seq.sv
// Top of the conversion sequencer. It accepts start requests only while idle,
// latches the channel, runs the fixed frame and publishes the result together
// with a one-cycle done pulse.
// Assumes: cmp_in settles within one converter period of a dac_code change.
module sar_adc_seq
    import sar_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int CH_BITS    = 3,
    parameter int FRAME_LEN  = 160,
    parameter int SAMPLE_LEN = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_BITS-1:0]  chan_sel,
    input  logic                slow_clk_sel,
    input  logic                cmp_in,
    output logic [CH_BITS-1:0]  mux_sel,
    output logic                sample_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                busy,
    output logic                done
);
    logic                start_acc;
    logic                tick;
    logic                trial_end;
    logic                frame_end;
    sar_phase_t          phase;
    logic [RES_BITS-1:0] value;

    assign start_acc = start & ~busy;

    sar_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .run       (busy),
        .div_sel   (slow_clk_sel),
        .tick      (tick)
    );

    sar_frame_ctl #(
        .RES_BITS   (RES_BITS),
        .FRAME_LEN  (FRAME_LEN),
        .SAMPLE_LEN (SAMPLE_LEN)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .tick      (tick),
        .busy      (busy),
        .phase     (phase),
        .trial_end (trial_end),
        .frame_end (frame_end)
    );

    sar_bit_reg #(
        .RES_BITS (RES_BITS)
    ) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .trial_on  (phase == PH_TRIAL),
        .trial_end (trial_end),
        .cmp_in    (cmp_in),
        .code      (dac_code),
        .value     (value)
    );

    assign sample_en = (phase == PH_SAMPLE);

    // Capture the channel only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         mux_sel <= '0;
        else if (start_acc) mux_sel <= chan_sel;
    end

    // Publish the result and the done pulse at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= frame_end;
            if (frame_end) result <= value;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(result)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mux_sel)); // R8
    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy); // R3
endmodule

// File: tb/sar_adc_seq_tb.sv
// Bench: models an ideal comparator against a stored input value and checks
// cycle-exact timing and results.
module sar_adc_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan_sel = '0;
    logic       slow_clk_sel = 1'b0;
    logic       cmp_in;
    logic [2:0] mux_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       busy;
    logic       done;
    logic [7:0] vin = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_adc_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .chan_sel     (chan_sel),
        .slow_clk_sel (slow_clk_sel),
        .cmp_in       (cmp_in),
        .mux_sel      (mux_sel),
        .sample_en    (sample_en),
        .dac_code     (dac_code),
        .result       (result),
        .busy         (busy),
        .done         (done)
    );

    // Ideal MSB-first search against an ideal comparator.
    function automatic logic [7:0] exp_code(input logic [7:0] v);
        logic [7:0] acc = '0;
        for (int b = 7; b >= 0; b--) begin
            logic [7:0] trial = acc | (8'h1 << b);
            if (v >= trial) acc = trial;
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One conversion, with checks on exact cycles; n counts negedges after the accepting edge.
    task automatic do_conv(input logic [2:0] ch, input logic dv, input logic [7:0] v, input bit poke);
        int m = dv ? 2 : 1;
        logic [7:0] prev = result;
        vin = v;
        @(negedge clk);
        start = 1'b1; chan_sel = ch; slow_clk_sel = dv;
        @(negedge clk);
        start = 1'b0; chan_sel = ~ch; slow_clk_sel = ~dv;
        for (int n = 1; n <= 160*m + 2; n++) begin
            if (n > 1) @(negedge clk);
            if (n == 1) begin
                chk(busy == 1'b1, "R2 busy", busy, 1);
                chk(sample_en == 1'b1, "R3 sample start", sample_en, 1);
                chk(mux_sel == ch, "R9 mux", mux_sel, ch);
            end
            if (n == 12*m) chk(sample_en == 1'b1, "R3 sample last", sample_en, 1);
            if (n == 12*m + 1) begin
                chk(sample_en == 1'b0, "R3 sample end", sample_en, 0);
                chk(dac_code == 8'h80, "R11 first trial", dac_code, 8'h80);
            end
            if (poke && n == 50) begin start = 1'b1; chan_sel = ch + 3'd1; end
            if (n == 51) start = 1'b0;
            if (n == 100) begin
                chk(result == prev, "R10 result hold", result, prev);
                chk(mux_sel == ch, "R8 R9 mux kept", mux_sel, ch);
            end
            if (n == 160*m) begin
                chk(busy == 1'b1 && done == 1'b0, "R4 R5 not yet done", {busy, done}, 2'b10);
            end
            if (n == 160*m + 1) begin
                chk(done == 1'b1 && busy == 1'b0, "R4 R5 R8 end time", {busy, done}, 2'b01);
                chk(result == exp_code(v), "R6 R7 result", result, exp_code(v));
            end
            if (n == 160*m + 2) chk(done == 1'b0, "R10 done pulse", done, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && sample_en == 1'b0 && result == 8'h00,
            "R1 reset", {busy, done, sample_en, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && result == 8'h00, "R1 idle", {busy, result}, 0);
        // Directed corner cases at both rates, with a start while busy.
        do_conv(3'd0, 1'b0, 8'h00, 1'b0);
        do_conv(3'd7, 1'b1, 8'hFF, 1'b1);
        do_conv(3'd4, 1'b0, 8'h80, 1'b1);
        do_conv(3'd2, 1'b1, 8'h01, 1'b0);
        do_conv(3'd5, 1'b0, 8'hFE, 1'b0);
        do_conv(3'd1, 1'b1, 8'h7F, 1'b0);
        // Random inputs, channels and rates.
        for (int i = 0; i < 20; i++) begin
            do_conv(3'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule